// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one fixed-width 32-bit instruction word into the control bundle that a simple register-to-register datapath needs. It is purely combinational, so an instruction register drives it and the decoded fields are valid in the same cycle. The opcode always sits in the top five bits. The layout of the rest of the word depends on the opcode. The long-address form (L) holds a 22-bit address or constant. The displacement form (D) holds a second register and a 17-bit signed constant. The extended form (X) holds two more registers and a 12-bit secondary opcode, and it is used when the primary opcode is 31.

The decoder returns the raw register fields, a selected and extended immediate, and a zero-extended jump target. It also returns an ALU operation code and the ALU operand source, a memory operation with its addressing mode, a branch kind, a register-write enable with its destination and write-back source, a trap indication with its code, and an illegal-instruction flag. Conditional branches test a named register for zero or nonzero, because the machine has no flags. The link and return operations use a register that the instruction names.

Top module: `tfd_decoder`

## Requirements
- R1: `rd_idx_o`, `rs2_idx_o` and `rs3_idx_o` always equal instruction bits [26:22], [21:17] and [16:12]. `wr_idx_o` equals bits [26:22], except for extended opcode 22 (pop), where it equals bits [21:17].
- R2: `imm_o` is bits [21:0] sign-extended when the primary opcode is 5, and bits [16:0] sign-extended for every other opcode. `target_o` is always bits [21:0] zero-extended.
- R3: Primary opcodes 10..25 give ALU code (opcode-10) with `alu_imm_o`=1, `reg_wr_o`=1 and write-back source ALU. The ALU codes are 0 add, 1 sub, 2 mul, 3 div, 4 and, 5 or, 6 xor, 7 eq, 8 ne, 9 lt, 10 le, 11 gt, 12 ge, 13 shl, 14 shr, 15 mod, 16 pass (copy of the first source), 17 not.
- R4: Under primary opcode 31, extended opcodes 0..15 give ALU code equal to the extended opcode with `alu_imm_o`=0. Extended opcode 16 gives pass and 23 gives not. All three cases write a register from the ALU. The ALU code is 0 for every other instruction, and `alu_imm_o` is 1 only for primary opcodes 2, 4 and 10..25.
- R5: Memory codes are 0 none, 1 load, 2 store, 3 push, 4 pop. Address modes are 0 absolute, 1 displacement, 2 indexed, 3 stack. The mapping is: primary 1 gives load/absolute; 2 gives load/displacement; 3 gives store/absolute; 4 gives store/displacement. Extended 17 gives load/indexed; 18 gives store/indexed; 21 gives push/stack; 22 gives pop/stack.
- R6: Branch codes are 0 none, 1 jump, 2 jump-if-nonzero, 3 jump-if-zero, 4 jump-and-link, 5 return. Primary 6, 8, 9 and 7 give codes 1, 2, 3 and 4. Extended 19 gives code 5.
- R7: Write-back sources are 0 ALU, 1 memory, 2 PC, 3 immediate. The loads and pop write from memory. Primary 5 writes from the immediate. Primary 7 writes the PC. Stores, push, jumps, return, trap and nop leave `reg_wr_o`=0.
- R8: Extended opcode 20 raises `trap_valid_o` with `trap_code_o` = bits [26:22] (0 stop, 1 print integer, 2 print character). Every other instruction gives `trap_valid_o`=0 and `trap_code_o`=0.
- R9: Primary opcodes 26..30, and extended opcodes 24..4095 under opcode 31, raise `illegal_o`. For these, `reg_wr_o`, the memory code, the branch code, the trap flag, the ALU code and `alu_imm_o` are all 0.
- R10: Primary opcode 0 (nop) gives every control output 0 and `illegal_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rd_idx_o | output | 5 | First register field |
| rs2_idx_o | output | 5 | Second register field |
| rs3_idx_o | output | 5 | Third register field |
| wr_idx_o | output | 5 | Register written by the instruction |
| imm_o | output | 32 | Selected sign-extended constant |
| target_o | output | 32 | Zero-extended jump target |
| alu_op_o | output | 5 | ALU operation code |
| alu_imm_o | output | 1 | Second ALU operand is the constant |
| mem_op_o | output | 3 | Memory operation code |
| addr_mode_o | output | 2 | Address mode code |
| branch_o | output | 3 | Branch kind code |
| reg_wr_o | output | 1 | Register write enable |
| wb_src_o | output | 2 | Write-back source code |
| trap_valid_o | output | 1 | Trap instruction present |
| trap_code_o | output | 5 | Trap number |
| illegal_o | output | 1 | Undefined encoding |

## Verification
Two decoder functions can apply to the same word at once. Jump-and-link is both a branch and a register write from the PC. Pop is both a stack memory access and a register write whose destination moves from the first to the second register field. The undefined-opcode check also takes priority over every other decode, including extended words whose low bits look like a valid ALU operation. The bench applies every primary and every defined extended opcode, the extended codes just beyond the defined range, and random words. On every clock it compares all outputs with a behavioural model, so it catches an overlap that drops one side as well as a suppression that fails to win.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
    localparam int OPC_W  = 5;
    localparam int REG_W  = 5;
    localparam int ADS_W  = 22;
    localparam int DISP_W = 17;
    localparam int XOP_W  = 12;
    localparam int OPC_LSB = 27;
    localparam int R1_LSB  = 22;
    localparam int R2_LSB  = 17;
    localparam int R3_LSB  = 12;

    localparam logic [OPC_W-1:0] OPC_EXT     = 5'd31;
    localparam logic [OPC_W-1:0] OPC_MOV_IMM = 5'd5;
    localparam logic [OPC_W-1:0] OPC_ALU_LO  = 5'd10;
    localparam logic [OPC_W-1:0] OPC_ALU_HI  = 5'd25;

    typedef enum logic [4:0] {
        ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_AND, ALU_OR, ALU_XOR, ALU_EQ,
        ALU_NE, ALU_LT, ALU_LE, ALU_GT, ALU_GE, ALU_SHL, ALU_SHR, ALU_MOD,
        ALU_PASS, ALU_NOT
    } alu_op_e;

    typedef enum logic [2:0] {MEM_NONE, MEM_LOAD, MEM_STORE, MEM_PUSH, MEM_POP} mem_op_e;
    typedef enum logic [1:0] {AM_ABS, AM_DISP, AM_INDEX, AM_STACK} addr_mode_e;
    typedef enum logic [2:0] {BR_NONE, BR_JUMP, BR_TRUE, BR_FALSE, BR_LINK, BR_RET} branch_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC, WB_IMM} wb_src_e;

    typedef struct packed {
        alu_op_e    alu_op;
        logic       alu_imm;
        mem_op_e    mem_op;
        addr_mode_e addr_mode;
        branch_e    branch;
        logic       reg_wr;
        logic       wr_sel_r2;
        wb_src_e    wb_src;
        logic       trap;
        logic       illegal;
    } ctrl_t;
endpackage

// File: rtl/tfd_fields.sv
module tfd_fields
    import tfd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]      word_i,
    output logic [OPC_W-1:0] opc_o,
    output logic [REG_W-1:0] r1_o,
    output logic [REG_W-1:0] r2_o,
    output logic [REG_W-1:0] r3_o,
    output logic [XOP_W-1:0] xop_o,
    output logic [XLEN-1:0]  imm_o,
    output logic [XLEN-1:0]  target_o
);
    localparam int SX_LONG = XLEN - ADS_W;
    localparam int SX_DISP = XLEN - DISP_W;

    logic [ADS_W-1:0]  ads;
    logic [DISP_W-1:0] disp;

    always_comb begin
        opc_o = word_i[OPC_LSB +: OPC_W];
        r1_o  = word_i[R1_LSB +: REG_W];
        r2_o  = word_i[R2_LSB +: REG_W];
        r3_o  = word_i[R3_LSB +: REG_W];
        xop_o = word_i[XOP_W-1:0];
        ads   = word_i[ADS_W-1:0];
        disp  = word_i[DISP_W-1:0];
        if (opc_o == OPC_MOV_IMM)
            imm_o = {{SX_LONG{ads[ADS_W-1]}}, ads};
        else
            imm_o = {{SX_DISP{disp[DISP_W-1]}}, disp};
        target_o = {{SX_LONG{1'b0}}, ads};
    end
endmodule

// File: rtl/tfd_primary.sv
module tfd_primary
    import tfd_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output ctrl_t            ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        if (opc_i >= OPC_ALU_LO && opc_i <= OPC_ALU_HI) begin
            ctrl_o.alu_op  = alu_op_e'(opc_i - OPC_ALU_LO);
            ctrl_o.alu_imm = 1'b1;
            ctrl_o.reg_wr  = 1'b1;
            ctrl_o.wb_src  = WB_ALU;
        end else begin
            unique case (opc_i)
                5'd0: ;
                5'd1: begin
                    ctrl_o.mem_op = MEM_LOAD;  ctrl_o.addr_mode = AM_ABS;
                    ctrl_o.reg_wr = 1'b1;      ctrl_o.wb_src    = WB_MEM;
                end
                5'd2: begin
                    ctrl_o.mem_op = MEM_LOAD;  ctrl_o.addr_mode = AM_DISP;
                    ctrl_o.alu_imm = 1'b1;
                    ctrl_o.reg_wr = 1'b1;      ctrl_o.wb_src    = WB_MEM;
                end
                5'd3: begin
                    ctrl_o.mem_op = MEM_STORE; ctrl_o.addr_mode = AM_ABS;
                end
                5'd4: begin
                    ctrl_o.mem_op = MEM_STORE; ctrl_o.addr_mode = AM_DISP;
                    ctrl_o.alu_imm = 1'b1;
                end
                5'd5: begin
                    ctrl_o.reg_wr = 1'b1;      ctrl_o.wb_src = WB_IMM;
                end
                5'd6: ctrl_o.branch = BR_JUMP;
                5'd7: begin
                    ctrl_o.branch = BR_LINK;
                    ctrl_o.reg_wr = 1'b1;      ctrl_o.wb_src = WB_PC;
                end
                5'd8: ctrl_o.branch = BR_TRUE;
                5'd9: ctrl_o.branch = BR_FALSE;
                OPC_EXT: ;
                default: ctrl_o.illegal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/tfd_extended.sv
module tfd_extended
    import tfd_pkg::*;
(
    input  logic [XOP_W-1:0] xop_i,
    output ctrl_t            ctrl_o
);
    localparam logic [XOP_W-1:0] XOP_ALU_HI = 12'd15;

    always_comb begin
        ctrl_o = '0;
        if (xop_i <= XOP_ALU_HI) begin
            ctrl_o.alu_op = alu_op_e'(xop_i[4:0]);
            ctrl_o.reg_wr = 1'b1;
            ctrl_o.wb_src = WB_ALU;
        end else begin
            unique case (xop_i)
                12'd16: begin
                    ctrl_o.alu_op = ALU_PASS; ctrl_o.reg_wr = 1'b1;
                end
                12'd17: begin
                    ctrl_o.mem_op = MEM_LOAD;  ctrl_o.addr_mode = AM_INDEX;
                    ctrl_o.reg_wr = 1'b1;      ctrl_o.wb_src    = WB_MEM;
                end
                12'd18: begin
                    ctrl_o.mem_op = MEM_STORE; ctrl_o.addr_mode = AM_INDEX;
                end
                12'd19: ctrl_o.branch = BR_RET;
                12'd20: ctrl_o.trap = 1'b1;
                12'd21: begin
                    ctrl_o.mem_op = MEM_PUSH;  ctrl_o.addr_mode = AM_STACK;
                end
                12'd22: begin
                    ctrl_o.mem_op = MEM_POP;   ctrl_o.addr_mode = AM_STACK;
                    ctrl_o.reg_wr = 1'b1;      ctrl_o.wb_src    = WB_MEM;
                    ctrl_o.wr_sel_r2 = 1'b1;
                end
                12'd23: begin
                    ctrl_o.alu_op = ALU_NOT;  ctrl_o.reg_wr = 1'b1;
                end
                default: ctrl_o.illegal = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/tfd_decoder.sv
module tfd_decoder
    import tfd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output logic [4:0]      rd_idx_o,
    output logic [4:0]      rs2_idx_o,
    output logic [4:0]      rs3_idx_o,
    output logic [4:0]      wr_idx_o,
    output logic [XLEN-1:0] imm_o,
    output logic [XLEN-1:0] target_o,
    output logic [4:0]      alu_op_o,
    output logic            alu_imm_o,
    output logic [2:0]      mem_op_o,
    output logic [1:0]      addr_mode_o,
    output logic [2:0]      branch_o,
    output logic            reg_wr_o,
    output logic [1:0]      wb_src_o,
    output logic            trap_valid_o,
    output logic [4:0]      trap_code_o,
    output logic            illegal_o
);
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] r1, r2, r3;
    logic [XOP_W-1:0] xop;
    ctrl_t            pri_ctrl, ext_ctrl, sel_ctrl, fin_ctrl;

    tfd_fields #(.XLEN(XLEN)) u_fields (
        .word_i  (instr_i),
        .opc_o   (opc),
        .r1_o    (r1),
        .r2_o    (r2),
        .r3_o    (r3),
        .xop_o   (xop),
        .imm_o   (imm_o),
        .target_o(target_o)
    );

    tfd_primary  u_primary  (.opc_i(opc), .ctrl_o(pri_ctrl));
    tfd_extended u_extended (.xop_i(xop), .ctrl_o(ext_ctrl));

    always_comb begin
        sel_ctrl = (opc == OPC_EXT) ? ext_ctrl : pri_ctrl;
        if (sel_ctrl.illegal) begin
            fin_ctrl         = '0;
            fin_ctrl.illegal = 1'b1;
        end else begin
            fin_ctrl = sel_ctrl;
        end
    end

    assign rd_idx_o     = r1;
    assign rs2_idx_o    = r2;
    assign rs3_idx_o    = r3;
    assign wr_idx_o     = fin_ctrl.wr_sel_r2 ? r2 : r1;
    assign alu_op_o     = fin_ctrl.alu_op;
    assign alu_imm_o    = fin_ctrl.alu_imm;
    assign mem_op_o     = fin_ctrl.mem_op;
    assign addr_mode_o  = fin_ctrl.addr_mode;
    assign branch_o     = fin_ctrl.branch;
    assign reg_wr_o     = fin_ctrl.reg_wr;
    assign wb_src_o     = fin_ctrl.wb_src;
    assign trap_valid_o = fin_ctrl.trap;
    assign trap_code_o  = fin_ctrl.trap ? r1 : 5'd0;
    assign illegal_o    = fin_ctrl.illegal;
endmodule

// File: rtl/tfd_decoder_chk.sv
module tfd_decoder_chk #(
    parameter int XLEN = 32
) (
    input logic [4:0]      opc_i,
    input logic [11:0]     xop_i,
    input logic [21:0]     ads_i,
    input logic [XLEN-1:0] target_i,
    input logic [2:0]      mem_op_i,
    input logic [2:0]      branch_i,
    input logic            reg_wr_i,
    input logic [1:0]      wb_src_i,
    input logic            trap_valid_i,
    input logic            illegal_i
);
    logic known;
    assign known = !$isunknown({opc_i, xop_i, ads_i});

    always_comb begin
        if (known) begin
            // R9
            illegal_quiet_chk: assert (!illegal_i ||
                (!reg_wr_i && mem_op_i == 3'd0 && branch_i == 3'd0 && !trap_valid_i))
                else $error("illegal word produced side effects");
            // R8
            trap_origin_chk: assert (!trap_valid_i || (opc_i == 5'd31 && xop_i == 12'd20))
                else $error("trap raised by non-trap word");
            // R6
            link_writes_pc_chk: assert (branch_i != 3'd4 || (reg_wr_i && wb_src_i == 2'd2))
                else $error("link without PC write");
            // R2
            target_zext_chk: assert (target_i == {{(XLEN-22){1'b0}}, ads_i})
                else $error("target not zero-extended address field");
            // R7
            store_no_write_chk: assert (!(mem_op_i == 3'd2 || mem_op_i == 3'd3) || !reg_wr_i)
                else $error("store or push writes a register");
        end
    end
endmodule

bind tfd_decoder tfd_decoder_chk #(.XLEN(XLEN)) u_chk (
    .opc_i       (instr_i[31:27]),
    .xop_i       (instr_i[11:0]),
    .ads_i       (instr_i[21:0]),
    .target_i    (target_o),
    .mem_op_i    (mem_op_o),
    .branch_i    (branch_o),
    .reg_wr_i    (reg_wr_o),
    .wb_src_i    (wb_src_o),
    .trap_valid_i(trap_valid_o),
    .illegal_i   (illegal_o)
);

// File: tb/tb_tfd_decoder.sv
module tb_tfd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'd0;

    logic [4:0]  rd_idx, rs2_idx, rs3_idx, wr_idx, alu_op, trap_code;
    logic [31:0] imm, target;
    logic        alu_imm, reg_wr, trap_valid, illegal;
    logic [2:0]  mem_op, branch;
    logic [1:0]  addr_mode, wb_src;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tfd_decoder dut (
        .instr_i(instr), .rd_idx_o(rd_idx), .rs2_idx_o(rs2_idx), .rs3_idx_o(rs3_idx),
        .wr_idx_o(wr_idx), .imm_o(imm), .target_o(target), .alu_op_o(alu_op),
        .alu_imm_o(alu_imm), .mem_op_o(mem_op), .addr_mode_o(addr_mode),
        .branch_o(branch), .reg_wr_o(reg_wr), .wb_src_o(wb_src),
        .trap_valid_o(trap_valid), .trap_code_o(trap_code), .illegal_o(illegal)
    );

    // expected values
    int e_wr, e_alu, e_aimm, e_mem, e_am, e_br, e_rw, e_wb, e_tv, e_tc, e_ill;
    logic [31:0] e_imm, e_tgt;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s instr=%h got=%0h exp=%0h", req, what, instr, got, exp);
        end
    endtask

    task automatic model(input logic [31:0] w);
        int op, x;
        op = int'(w[31:27]);
        x  = int'(w[11:0]);
        e_wr = int'(w[26:22]);
        e_alu = 0; e_aimm = 0; e_mem = 0; e_am = 0; e_br = 0;
        e_rw = 0; e_wb = 0; e_tv = 0; e_tc = 0; e_ill = 0;
        if (op == 5) e_imm = {{10{w[21]}}, w[21:0]};
        else         e_imm = {{15{w[16]}}, w[16:0]};
        e_tgt = {10'd0, w[21:0]};
        if ((op >= 26 && op <= 30) || (op == 31 && x >= 24)) begin
            e_ill = 1;
        end else if (op == 31) begin
            if (x < 16)       begin e_alu = x;  e_rw = 1; end
            else if (x == 16) begin e_alu = 16; e_rw = 1; end
            else if (x == 23) begin e_alu = 17; e_rw = 1; end
            else if (x == 17) begin e_mem = 1; e_am = 2; e_rw = 1; e_wb = 1; end
            else if (x == 18) begin e_mem = 2; e_am = 2; end
            else if (x == 19) e_br = 5;
            else if (x == 20) begin e_tv = 1; e_tc = int'(w[26:22]); end
            else if (x == 21) begin e_mem = 3; e_am = 3; end
            else begin e_mem = 4; e_am = 3; e_rw = 1; e_wb = 1; e_wr = int'(w[21:17]); end
        end else if (op >= 10) begin
            e_alu = op - 10; e_aimm = 1; e_rw = 1;
        end else begin
            if (op == 1 || op == 2) begin e_mem = 1; e_rw = 1; e_wb = 1; end
            if (op == 3 || op == 4) e_mem = 2;
            if (op == 2 || op == 4) begin e_am = 1; e_aimm = 1; end
            if (op == 5) begin e_rw = 1; e_wb = 3; end
            if (op == 6) e_br = 1;
            if (op == 7) begin e_br = 4; e_rw = 1; e_wb = 2; end
            if (op == 8) e_br = 2;
            if (op == 9) e_br = 3;
        end
    endtask

    task automatic compare_all();
        model(instr);
        chk("R1", "rd",     rd_idx,  instr[26:22]);
        chk("R1", "rs2",    rs2_idx, instr[21:17]);
        chk("R1", "rs3",    rs3_idx, instr[16:12]);
        chk("R1", "wr_idx", wr_idx,  e_wr);
        chk("R2", "imm",    imm,     e_imm);
        chk("R2", "target", target,  e_tgt);
        chk("R3", "alu_op", alu_op,  e_alu);
        chk("R4", "alu_imm", alu_imm, e_aimm);
        chk("R5", "mem_op", mem_op,  e_mem);
        chk("R5", "addr_mode", addr_mode, e_am);
        chk("R6", "branch", branch,  e_br);
        chk("R7", "reg_wr", reg_wr,  e_rw);
        chk("R7", "wb_src", wb_src,  e_wb);
        chk("R8", "trap_valid", trap_valid, e_tv);
        chk("R8", "trap_code",  trap_code,  e_tc);
        chk("R9", "illegal", illegal, e_ill);
    endtask

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        #1 instr = w;
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [31:0] rnd_fields(input logic [4:0] op);
        logic [31:0] r;
        r = $urandom;
        r[31:27] = op;
        return r;
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10: nop with zero word is the idle state after reset
        @(negedge clk);
        compare_all();
        chk("R10", "nop idle", {alu_op, mem_op, branch, reg_wr, trap_valid, illegal}, 0);
        // R10: nop with busy fields
        apply(32'h07FF_FFFF);
        chk("R10", "nop busy fields", {reg_wr, illegal}, 0);
        // every primary opcode, two field patterns each (R3 R5 R6 R7 R9)
        for (int op = 0; op < 31; op++) begin
            apply(rnd_fields(5'(op)));
            apply({5'(op), 5'd3, 5'd9, 17'h10000});
        end
        // R2: sign extension of both immediate widths
        apply({5'd5, 5'd1, 22'h200000});
        chk("R2", "mov imm negative", imm, 32'hFFE0_0000);
        apply({5'd5, 5'd1, 22'h1FFFFF});
        chk("R2", "mov imm positive", imm, 32'h001F_FFFF);
        apply({5'd10, 5'd1, 5'd2, 17'h1FFFF});
        chk("R2", "disp minus one", imm, 32'hFFFF_FFFF);
        // every defined extended opcode plus edges (R4 R5 R6 R8 R9)
        for (int x = 0; x < 32; x++) begin
            logic [31:0] w;
            w = rnd_fields(5'd31);
            w[11:0] = 12'(x);
            apply(w);
        end
        // R8: trap codes stop, print integer, print character
        for (int t = 0; t < 3; t++) begin
            apply({5'd31, 5'(t), 5'd7, 5'd7, 12'd20});
            chk("R8", "trap code", trap_code, t);
        end
        // R1: pop moves destination to second field
        apply({5'd31, 5'd4, 5'd11, 5'd0, 12'd22});
        chk("R1", "pop wr_idx", wr_idx, 11);
        // R9: largest and first undefined extended codes, low bits mimicking ALU ops
        apply({5'd31, 5'd1, 5'd2, 5'd3, 12'hFFF});
        apply({5'd31, 5'd1, 5'd2, 5'd3, 12'd24});
        apply({5'd31, 5'd1, 5'd2, 5'd3, 12'h100});
        chk("R9", "xop 256 illegal", illegal, 1);
        apply({5'd31, 5'd1, 5'd2, 5'd3, 12'd23});
        chk("R4", "not stays legal", {illegal, alu_op}, 17);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            w = $urandom;
            if (i % 2 == 0) begin
                w[31:27] = 5'd31;
                w[11:0]  = 12'($urandom_range(0, 40));
            end
            apply(w);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule